// File: doc/BRIEF.md
# Fractional Clock-Enable Multiplier with Committed Ratio Updates

The block produces a clock-enable stream whose average rate is the input clock scaled by M/32, with M anywhere from 1 to 32. It drops selected input cycles (pulse swallowing): a 5-bit accumulator gains M every cycle, and each carry out of it enables one cycle. Over any 32 consecutive cycles with a fixed ratio this gives exactly M enables. The ratio is stored as 32 minus M, so a cleared field means full rate.

Software sees two registers. The rate register holds the ratio field among bits it may use freely. The command register holds a go bit. A new field is only staged until software sets the go bit. The block then waits for the end of its free-running 32-cycle window and makes the staged field active there, so no window mixes two ratios. One cycle later it clears the go bit by itself. While the go bit reads 1, the block refuses writes to the rate register and further go requests.

Top module: `frac_clk_mult`

## Requirements
- R1: After reset the rate register reads 0, the command register reads 0 and the enable output is high on every cycle.
- R2: The ratio field is bits 12:8 of the rate register at byte address 0x0. The active multiplier is M = 32 - field, so field 0 gives M = 32 and field 31 gives M = 1.
- R3: With a fixed active ratio, every 32-cycle window of the internal window counter holds exactly M enable cycles. So does any run of 32 consecutive cycles.
- R4: A write to the rate register does not change the enable output until a go request is committed.
- R5: Writing 1 to bit 31 of the command register at byte address 0x4 while idle sets that bit. It reads 1 from the next cycle until the update completes.
- R6: The staged field becomes active only on the first cycle of a window. The last window under the old ratio holds exactly M_old enables and the first window under the new ratio holds exactly M_new.
- R7: The go bit clears on the cycle after the ratio is committed, which is 2 to 33 cycles after the cycle the go request was accepted.
- R8: While the go bit reads 1, writes to the rate register are ignored and its read value stays unchanged.
- R9: Rate-register bits outside 12:8 are stored and read back exactly as written, and have no effect on the enable output.
- R10: A command-register write with bit 31 at 0 does nothing. All command-register bits other than bit 31 read 0.
- R11: When the active field is 0, the enable output is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte address (0x0 rate, 0x4 command) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| clk_en_o | output | 1 | Swallowed clock-enable stream |

## Verification
The assertions assume that the bus performs at most one access per cycle and that address and data are stable at the sampling edge. The per-window enable count also assumes the active ratio can only change at a window edge, which the commit logic guarantees. The bench drives the bus only just after the falling edge and holds each strobe for exactly one rising edge. Random fields and random surrounding bits are kept within the 5-bit field and the 32-bit register. A busy-time write is issued only in the cycle after a go request is accepted, when the go bit is certain to still be set.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } commit_st_e;
endpackage

// File: rtl/fcm_window.sv
module fcm_window #(
  parameter int unsigned WIN_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_last_o
);
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_q + 1'b1;
  end

  assign win_last_o = &win_q;
endmodule

// File: rtl/fcm_regif.sv
module fcm_regif #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned KICK_BIT  = 31,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_valid_i,
  input  logic               bus_write_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               busy_i,
  output logic [FIELD_W-1:0] staged_field_o,
  output logic               kick_req_o
);
  logic [DATA_W-1:0] rate_q;
  logic              wr_ok;
  logic              rate_we;

  assign wr_ok      = bus_valid_i && bus_write_i && !busy_i;
  assign rate_we    = wr_ok && (bus_addr_i == RATE_ADDR);
  assign kick_req_o = wr_ok && (bus_addr_i == CMD_ADDR) && bus_wdata_i[KICK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rate_q <= '0;
    else if (rate_we) rate_q <= bus_wdata_i;
  end

  assign staged_field_o = rate_q[FIELD_LSB +: FIELD_W];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == RATE_ADDR)     bus_rdata_o = rate_q;
    else if (bus_addr_i == CMD_ADDR) bus_rdata_o[KICK_BIT] = busy_i;
  end

  AST_BUSY_LOCKS_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(rate_q)); // R8
  AST_NO_KICK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !kick_req_o); // R8
endmodule

// File: rtl/fcm_commit.sv
module fcm_commit
  import fcm_pkg::*;
#(
  parameter int unsigned FIELD_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               kick_req_i,
  input  logic [FIELD_W-1:0] staged_field_i,
  input  logic               win_last_i,
  output logic               busy_o,
  output logic [FIELD_W-1:0] active_field_o
);
  commit_st_e        st_q;
  logic [FIELD_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      active_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (kick_req_i) st_q <= ST_WAIT;
        ST_WAIT: if (win_last_i) begin
          active_q <= staged_field_i;  // copy only at window end
          st_q     <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (st_q != ST_IDLE);
  assign active_field_o = active_q;

  AST_COMMIT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> $past(win_last_i)); // R6
  AST_KICK_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(win_last_i, 2)); // R7
  AST_KICK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(kick_req_i)); // R5
endmodule

// File: rtl/fcm_swallow.sv
module fcm_swallow #(
  parameter int unsigned FIELD_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] active_field_i,
  input  logic               win_last_i,
  output logic               en_o
);
  localparam int unsigned MW  = FIELD_W + 1;
  localparam int unsigned DEN = 1 << FIELD_W;

  logic [FIELD_W-1:0] acc_q;
  logic [MW-1:0]      mult;
  logic [MW-1:0]      sum;
  logic [MW-1:0]      cnt_q;

  assign mult = MW'(DEN) - {1'b0, active_field_i};
  assign sum  = {1'b0, acc_q} + mult;
  assign en_o = sum[FIELD_W];  // carry out of the accumulator

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[FIELD_W-1:0];
  end

  // enable count within the current window, for checking only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (win_last_i) cnt_q <= '0;
    else                 cnt_q <= cnt_q + MW'(en_o);
  end

  AST_WINDOW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_last_i |-> ((cnt_q + MW'(en_o)) == mult)); // R3
  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_field_i == '0) |-> en_o); // R11
  AST_MULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mult != '0) && (mult <= MW'(DEN))); // R2
endmodule

// File: rtl/frac_clk_mult.sv
module frac_clk_mult #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned KICK_BIT  = 31,
  parameter logic [ADDR_W-1:0] RATE_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              clk_en_o
);
  logic               win_last;
  logic               busy;
  logic               kick_req;
  logic [FIELD_W-1:0] staged_field;
  logic [FIELD_W-1:0] active_field;

  fcm_window #(.WIN_W(FIELD_W)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_last_o (win_last)
  );

  fcm_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
    .KICK_BIT(KICK_BIT), .RATE_ADDR(RATE_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_regif (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bus_valid_i    (bus_valid_i),
    .bus_write_i    (bus_write_i),
    .bus_addr_i     (bus_addr_i),
    .bus_wdata_i    (bus_wdata_i),
    .bus_rdata_o    (bus_rdata_o),
    .busy_i         (busy),
    .staged_field_o (staged_field),
    .kick_req_o     (kick_req)
  );

  fcm_commit #(.FIELD_W(FIELD_W)) u_commit (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .kick_req_i     (kick_req),
    .staged_field_i (staged_field),
    .win_last_i     (win_last),
    .busy_o         (busy),
    .active_field_o (active_field)
  );

  fcm_swallow #(.FIELD_W(FIELD_W)) u_swallow (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .active_field_i (active_field),
    .win_last_i     (win_last),
    .en_o           (clk_en_o)
  );
endmodule

// File: tb/frac_clk_mult_bench.sv
module frac_clk_mult_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_RATE = 4'h0;
  localparam logic [3:0] A_CMD  = 4'h4;
  localparam logic [31:0] FIELD_MASK = 32'h0000_1F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = A_CMD;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_en;

  logic [63:0] hist = '0;
  int n_chk = 0;
  int n_bad = 0;
  int m_cur = 32;
  logic [31:0] rate_cur = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_clk_mult u_frac_clk_mult (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .clk_en_o(clk_en)
  );

  function automatic int mult_of(input logic [31:0] rv);
    return 32 - int'(rv[12:8]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = A_CMD;
    #1;
    hist = {hist[62:0], clk_en};
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = A_CMD;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // go request, wait for clear, check both sides of the committed edge
  task automatic commit(input int m_new, input logic check_old);
    logic [31:0] d;
    int n;
    int m_old;
    m_old = m_cur;
    wr(A_CMD, 32'h8000_0000);
    rd(A_CMD, d);
    chk("R5 go bit set", int'(d[31]), 1);
    n = 0;
    while (d[31] && n < 40) begin
      tick();
      n++;
      rd(A_CMD, d);
    end
    chk("R7 go bit cleared", int'(d[31]), 0);
    chk("R7 clear latency in range", int'(n >= 2 && n <= 33), 1);
    ticks(30);
    chk("R6 first new window", $countones(hist[31:0]), m_new);
    if (check_old) chk("R6 last old window", $countones(hist[63:32]), m_old);
    m_cur = m_new;
  endtask

  task automatic do_case(input logic [31:0] rv);
    logic [31:0] d;
    wr(A_RATE, rv);
    rd(A_RATE, d);
    chk("R9 rate readback", int'(d == rv), 1);
    chk("R2 field readback", int'(d[12:8]), int'(rv[12:8]));
    ticks(32);
    chk("R4 staged only, output unchanged", $countones(hist[31:0]), m_cur);
    commit(mult_of(rv), 1'b1);
    rate_cur = rv;
    ticks(32);
    chk("R3 steady count", $countones(hist[31:0]), m_cur);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] rv;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    ticks(3);
    rst_n = 1'b1;
    tick();
    rd(A_RATE, d);
    chk("R1 rate reset", int'(d), 0);
    rd(A_CMD, d);
    chk("R1 command reset", int'(d), 0);
    ticks(40);
    chk("R1 full rate after reset", $countones(hist[31:0]), 32);
    chk("R11 field 0 continuous", int'(&hist[39:0]), 1);

    // directed extremes
    do_case(32'h0000_1F00);           // M=1
    do_case(32'hA5A5_00A5 & ~FIELD_MASK); // M=32, other bits set
    chk("R11 field 0 continuous again", int'(&hist[31:0]), 1);
    do_case(32'h0000_1000);           // M=16
    do_case(32'hFFFF_FFFF);           // M=1, all other bits set

    // R10: command write without go bit
    wr(A_RATE, 32'h0000_0300);        // stage M=29
    wr(A_CMD, 32'h7FFF_FFFF);
    rd(A_CMD, d);
    chk("R10 command reads zero", int'(d), 0);
    ticks(32);
    chk("R10 no commit without go bit", $countones(hist[31:0]), m_cur);
    commit(29, 1'b1);
    rate_cur = 32'h0000_0300;

    // R8: rate write while busy is ignored
    wr(A_RATE, 32'h0000_0800);        // stage M=24
    ticks(32);
    wr(A_CMD, 32'h8000_0000);
    wr(A_RATE, 32'h1234_1A00);        // during busy
    rd(A_RATE, d);
    chk("R8 busy write ignored", int'(d == 32'h0000_0800), 1);
    rd(A_CMD, d);
    begin
      int n = 0;
      while (d[31] && n < 40) begin tick(); n++; rd(A_CMD, d); end
    end
    chk("R8 go bit cleared", int'(d[31]), 0);
    ticks(32);
    chk("R8 staged value applied", $countones(hist[31:0]), 24);
    m_cur = 24;

    // random mix
    for (int k = 0; k < 12; k++) begin
      rv = ($urandom() & ~FIELD_MASK) | ({27'd0, 5'($urandom_range(31, 0))} << 8);
      do_case(rv);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule